// File: doc/BRIEF.md
# Queue Status Interrupt Source Selector

This block turns the status flags of a bank of hardware queues into interrupt requests. Each queue in the lower group has four flags from the queue engine: empty, nearly empty, nearly full and full. A 4-bit select field for each lower queue chooses which flag matters, and whether the flag itself or its inverse is watched. When the watched condition goes from 0 to 1 and the queue's enable bit is set, a sticky pending bit for that queue is set. Queues in the upper group have no select field. Their source is always their nearly-empty flag.

Software configures the block through a simple word-wide register port. It writes the select words and the two enable masks. It reads the two pending masks and clears the bits it has serviced by writing ones to them. A single interrupt line stays high while any pending bit is also enabled. The queue storage, and the logic that computes the flags, sit outside this block.

Top module: `qirq_top`

## Requirements
- R1: After reset, every select word, both enable masks and both pending masks read 0, and `irq` is 0.
- R2: Select words sit at word addresses 0 to 3. Lower queue k owns bits [4*(k%8)+3 : 4*(k%8)] of word k/8, and all 4 bits read back as written. Addresses 4 to 7 and 12 to 15 read 0, and writes to them change nothing. The lower enable mask is at address 8, the upper enable mask at 9, the lower pending mask at 10 and the upper pending mask at 11. Bit i of each mask belongs to queue i of its group.
- R3: In a select field, bits [1:0] choose the flag: 0 = empty, 1 = nearly empty, 2 = nearly full, 3 = full. Bit 2 = 1 watches the inverse of that flag. Bit 3 has no effect on which condition is watched.
- R4: A lower pending bit is set at the clock edge where its watched condition is 1 and was 0 at the previous edge, provided its enable bit was 1 at that edge. The bit reads back as 1, and `irq` can rise, right after that single edge.
- R5: While a queue's enable bit is 0, a rising condition never sets its pending bit. Setting the enable bit while the condition is already high sets nothing, because no rising edge occurs.
- R6: A pending bit stays set after its condition falls, until software clears it.
- R7: Writing to a pending mask clears exactly the bits written as 1. Bits written as 0 are left unchanged.
- R8: If a new event for a queue arrives at the same edge as a write that clears that queue's bit, the bit ends up set.
- R9: An upper pending bit is set when that queue's nearly-empty input rises while its upper enable bit is 1. The lower select words have no influence on it.
- R10: `irq` is 1 exactly when some pending bit is set in either group together with its enable bit. Clearing an enable bit drops `irq` but leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe for this cycle |
| regAddr | input | 4 | Word address for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| lowEmpty | input | LOW_Q | Empty flag per lower queue |
| lowNearEmpty | input | LOW_Q | Nearly-empty flag per lower queue |
| lowNearFull | input | LOW_Q | Nearly-full flag per lower queue |
| lowFull | input | LOW_Q | Full flag per lower queue |
| uppNearEmpty | input | UPP_Q | Nearly-empty flag per upper queue |
| irq | output | 1 | High while any enabled pending bit is set |

## Verification
The bench builds the block with its defaults, LOW_Q = 32 and UPP_Q = 32. With these values both groups fill a whole data word and all four select words exist. This brings the top nibble (queue 31) and the top upper bit within reach, and leaves the address holes 4 to 7 and 12 to 15 open to stray writes. All sixteen select codes are driven on one queue, including those with the unused bit set. A long random run then mixes flag toggles with writes to every address, including clears that collide with new events.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  localparam int SEL_W     = 4;
  localparam int Q_PER_SEL = DATA_W / SEL_W;
  localparam int SIDX_W    = 3;

  localparam logic [ADDR_W-1:0] ADDR_EN_LOW  = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_EN_UPP  = 4'h9;
  localparam logic [ADDR_W-1:0] ADDR_INT_LOW = 4'hA;
  localparam logic [ADDR_W-1:0] ADDR_INT_UPP = 4'hB;

  // flag chosen by the low two bits of a select field
  typedef enum logic [1:0] {
    SRC_EMPTY      = 2'd0,
    SRC_NEAR_EMPTY = 2'd1,
    SRC_NEAR_FULL  = 2'd2,
    SRC_FULL       = 2'd3
  } srcFlag_e;

  // strobes from the register decoder into the datapath
  typedef struct packed {
    logic              selWr;
    logic [SIDX_W-1:0] selIdx;
    logic              enLowWr;
    logic              enUppWr;
    logic              clrLowWr;
    logic              clrUppWr;
  } ctrlStrobe_t;

endpackage

// File: rtl/qirq_srcmux.sv
module qirq_srcmux
  import qirq_pkg::*;
(
  input  logic [2:0] srcSel,
  input  logic       empty,
  input  logic       nearEmpty,
  input  logic       nearFull,
  input  logic       full,
  output logic       cond
);

  srcFlag_e pick;
  logic     raw;

  always_comb begin
    pick = srcFlag_e'(srcSel[1:0]);
    unique case (pick)
      SRC_EMPTY:      raw = empty;
      SRC_NEAR_EMPTY: raw = nearEmpty;
      SRC_NEAR_FULL:  raw = nearFull;
      SRC_FULL:       raw = full;
      default:        raw = 1'b0;
    endcase
    cond = raw ^ srcSel[2];
  end

endmodule

// File: rtl/qirq_regctl.sv
module qirq_regctl
  import qirq_pkg::*;
#(
  parameter int LOW_Q = 32,
  parameter int UPP_Q = 32
) (
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [LOW_Q*SEL_W-1:0] selFlat,
  input  logic [LOW_Q-1:0]       enLow,
  input  logic [UPP_Q-1:0]       enUpp,
  input  logic [LOW_Q-1:0]       intLow,
  input  logic [UPP_Q-1:0]       intUpp,
  output ctrlStrobe_t            strobe,
  output logic [DATA_W-1:0]      regRdData
);

  localparam int SEL_REGS = LOW_Q / Q_PER_SEL;
  localparam int RIDX_W   = (SEL_REGS > 1) ? $clog2(SEL_REGS) : 1;

  logic                   inSelSpace;
  logic [DATA_W-1:0]      selWords [SEL_REGS];
  logic [SIDX_W-1:0]      wordIdx;

  assign wordIdx    = regAddr[SIDX_W-1:0];
  assign inSelSpace = !regAddr[ADDR_W-1] && (int'(wordIdx) < SEL_REGS);

  for (genvar r = 0; r < SEL_REGS; r++) begin : gWord
    assign selWords[r] = selFlat[r*DATA_W +: DATA_W];
  end

  always_comb begin
    strobe          = '0;
    strobe.selWr    = regWrEn && inSelSpace;
    strobe.selIdx   = wordIdx;
    strobe.enLowWr  = regWrEn && (regAddr == ADDR_EN_LOW);
    strobe.enUppWr  = regWrEn && (regAddr == ADDR_EN_UPP);
    strobe.clrLowWr = regWrEn && (regAddr == ADDR_INT_LOW);
    strobe.clrUppWr = regWrEn && (regAddr == ADDR_INT_UPP);
  end

  always_comb begin
    regRdData = '0;
    if (inSelSpace) begin
      regRdData = selWords[wordIdx[RIDX_W-1:0]];
    end else begin
      case (regAddr)
        ADDR_EN_LOW:  regRdData = DATA_W'(enLow);
        ADDR_EN_UPP:  regRdData = DATA_W'(enUpp);
        ADDR_INT_LOW: regRdData = DATA_W'(intLow);
        ADDR_INT_UPP: regRdData = DATA_W'(intUpp);
        default:      regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/qirq_datapath.sv
module qirq_datapath
  import qirq_pkg::*;
#(
  parameter int LOW_Q = 32,
  parameter int UPP_Q = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [LOW_Q-1:0]       lowEmpty,
  input  logic [LOW_Q-1:0]       lowNearEmpty,
  input  logic [LOW_Q-1:0]       lowNearFull,
  input  logic [LOW_Q-1:0]       lowFull,
  input  logic [UPP_Q-1:0]       uppNearEmpty,
  output logic [LOW_Q*SEL_W-1:0] selFlat,
  output logic [LOW_Q-1:0]       enLow,
  output logic [UPP_Q-1:0]       enUpp,
  output logic [LOW_Q-1:0]       intLow,
  output logic [UPP_Q-1:0]       intUpp,
  output logic                   irq
);

  logic [LOW_Q-1:0] condLow;
  logic [LOW_Q-1:0] prevLow;
  logic [UPP_Q-1:0] prevUpp;
  logic [LOW_Q-1:0] evtLow;
  logic [UPP_Q-1:0] evtUpp;
  logic [LOW_Q-1:0] clrLow;
  logic [UPP_Q-1:0] clrUpp;

  // one select field and one condition mux per lower queue
  for (genvar q = 0; q < LOW_Q; q++) begin : gQ
    localparam int WORD = q / Q_PER_SEL;
    localparam int LANE = q % Q_PER_SEL;
    logic [SEL_W-1:0] selQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ <= '0;
      end else if (strobe.selWr && (strobe.selIdx == SIDX_W'(WORD))) begin
        selQ <= wrData[LANE*SEL_W +: SEL_W];
      end
    end

    assign selFlat[q*SEL_W +: SEL_W] = selQ;

    qirq_srcmux uMux (
      .srcSel    (selQ[2:0]),
      .empty     (lowEmpty[q]),
      .nearEmpty (lowNearEmpty[q]),
      .nearFull  (lowNearFull[q]),
      .full      (lowFull[q]),
      .cond      (condLow[q])
    );
  end

  always_comb begin
    evtLow = enLow & condLow & ~prevLow;
    evtUpp = enUpp & uppNearEmpty & ~prevUpp;
    clrLow = strobe.clrLowWr ? wrData[LOW_Q-1:0] : '0;
    clrUpp = strobe.clrUppWr ? wrData[UPP_Q-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLow   <= '0;
      enUpp   <= '0;
      intLow  <= '0;
      intUpp  <= '0;
      prevLow <= '0;
      prevUpp <= '0;
    end else begin
      if (strobe.enLowWr) enLow <= wrData[LOW_Q-1:0];
      if (strobe.enUppWr) enUpp <= wrData[UPP_Q-1:0];
      // a new event overrides a clear of the same bit
      intLow  <= (intLow & ~clrLow) | evtLow;
      intUpp  <= (intUpp & ~clrUpp) | evtUpp;
      prevLow <= condLow;
      prevUpp <= uppNearEmpty;
    end
  end

  assign irq = (|(intLow & enLow)) | (|(intUpp & enUpp));

endmodule

// File: rtl/qirq_top.sv
module qirq_top
  import qirq_pkg::*;
#(
  parameter int LOW_Q = 32,
  parameter int UPP_Q = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [LOW_Q-1:0]  lowEmpty,
  input  logic [LOW_Q-1:0]  lowNearEmpty,
  input  logic [LOW_Q-1:0]  lowNearFull,
  input  logic [LOW_Q-1:0]  lowFull,
  input  logic [UPP_Q-1:0]  uppNearEmpty,
  output logic              irq
);

  ctrlStrobe_t            strobe;
  logic [LOW_Q*SEL_W-1:0] selFlat;
  logic [LOW_Q-1:0]       enLow;
  logic [UPP_Q-1:0]       enUpp;
  logic [LOW_Q-1:0]       intLow;
  logic [UPP_Q-1:0]       intUpp;

  qirq_regctl #(.LOW_Q(LOW_Q), .UPP_Q(UPP_Q)) uCtl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .selFlat   (selFlat),
    .enLow     (enLow),
    .enUpp     (enUpp),
    .intLow    (intLow),
    .intUpp    (intUpp),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  qirq_datapath #(.LOW_Q(LOW_Q), .UPP_Q(UPP_Q)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (regWrData),
    .lowEmpty     (lowEmpty),
    .lowNearEmpty (lowNearEmpty),
    .lowNearFull  (lowNearFull),
    .lowFull      (lowFull),
    .uppNearEmpty (uppNearEmpty),
    .selFlat      (selFlat),
    .enLow        (enLow),
    .enUpp        (enUpp),
    .intLow       (intLow),
    .intUpp       (intUpp),
    .irq          (irq)
  );

endmodule

// File: rtl/qirq_checker.sv
module qirq_checker
  import qirq_pkg::*;
#(
  parameter int LOW_Q = 32,
  parameter int UPP_Q = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [UPP_Q-1:0]  uppNearEmpty,
  input logic [LOW_Q-1:0]  enLow,
  input logic [UPP_Q-1:0]  enUpp,
  input logic [LOW_Q-1:0]  intLow,
  input logic [UPP_Q-1:0]  intUpp,
  input logic              irq
);

  logic [LOW_Q-1:0] wrClrLow;
  logic [UPP_Q-1:0] wrClrUpp;

  assign wrClrLow = (regWrEn && regAddr == ADDR_INT_LOW) ? regWrData[LOW_Q-1:0] : '0;
  assign wrClrUpp = (regWrEn && regAddr == ADDR_INT_UPP) ? regWrData[UPP_Q-1:0] : '0;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> (intLow == '0 && intUpp == '0 && enLow == '0 && enUpp == '0));

  assert_no_set_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((intLow & ~$past(intLow) & ~$past(enLow)) == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(intLow) & ~$past(wrClrLow) & ~intLow) == '0)
          && (($past(intUpp) & ~$past(wrClrUpp) & ~intUpp) == '0));

  assert_upp_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((intUpp & ~$past(intUpp) &
               ~($past(uppNearEmpty) & ~$past(uppNearEmpty, 2))) == '0));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(regWrEn) || intLow != $past(intLow) || intUpp != $past(intUpp)));

endmodule

bind qirq_top qirq_checker #(.LOW_Q(LOW_Q), .UPP_Q(UPP_Q)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .regWrData    (regWrData),
  .uppNearEmpty (uppNearEmpty),
  .enLow        (enLow),
  .enUpp        (enUpp),
  .intLow       (intLow),
  .intUpp       (intUpp),
  .irq          (irq)
);

// File: tb/sim_qirq_top.sv
`timescale 1ns/10ps
module sim_qirq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] fE = '0, fNE = '0, fNF = '0, fF = '0, fU = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [3:0]  mSel [32];
  logic [31:0] mEnL, mEnU, mIntL, mIntU, mPrevL, mPrevU;

  always #10 clk = ~clk;

  qirq_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .lowEmpty(fE), .lowNearEmpty(fNE), .lowNearFull(fNF), .lowFull(fF),
    .uppNearEmpty(fU), .irq(irq)
  );

  function automatic logic condOf(int q);
    logic [3:0] fl;
    fl = {fF[q], fNF[q], fNE[q], fE[q]};
    return fl[mSel[q][1:0]] ^ mSel[q][2];
  endfunction

  function automatic logic [31:0] modelRead(logic [3:0] a);
    logic [31:0] v;
    v = '0;
    if (a < 4) begin
      for (int j = 0; j < 8; j++) v[j*4 +: 4] = mSel[a*8 + j];
    end else if (a == 4'h8) v = mEnL;
    else if (a == 4'h9) v = mEnU;
    else if (a == 4'hA) v = mIntL;
    else if (a == 4'hB) v = mIntU;
    return v;
  endfunction

  function automatic logic modelIrq();
    return (|(mIntL & mEnL)) | (|(mIntU & mEnU));
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readLit(input string tag, input logic [3:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.1;
    checkEq(tag, regRdData, exp);
  endtask

  task automatic readChk(input string tag, input logic [3:0] a);
    readLit(tag, a, modelRead(a));
  endtask

  // one clock cycle with an optional write; model follows the requirements
  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] cL, evL, evU, clrL, clrU;
    regWrEn = wr; regAddr = a; regWrData = d;
    for (int q = 0; q < 32; q++) cL[q] = condOf(q);
    evL  = mEnL & cL & ~mPrevL;
    evU  = mEnU & fU & ~mPrevU;
    clrL = (wr && a == 4'hA) ? d : '0;
    clrU = (wr && a == 4'hB) ? d : '0;
    @(posedge clk);
    @(negedge clk);
    mIntL  = (mIntL & ~clrL) | evL;
    mIntU  = (mIntU & ~clrU) | evU;
    mPrevL = cL;
    mPrevU = fU;
    if (wr) begin
      if (a < 4) begin
        for (int j = 0; j < 8; j++) mSel[a*8 + j] = d[j*4 +: 4];
      end else if (a == 4'h8) mEnL = d;
      else if (a == 4'h9) mEnU = d;
    end
    regWrEn = 1'b0;
    checkEq("R10 irq level", {31'd0, irq}, {31'd0, modelIrq()});
  endtask

  task automatic idle();
    cyc(1'b0, 4'h0, 32'h0);
  endtask

  task automatic setFlag(input int f, input int q, input logic v);
    case (f)
      0: fE[q] = v;
      1: fNE[q] = v;
      2: fNF[q] = v;
      default: fF[q] = v;
    endcase
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int q = 0; q < 32; q++) mSel[q] = '0;
    mEnL = '0; mEnU = '0; mIntL = '0; mIntU = '0; mPrevL = '0; mPrevU = '0;
    void'($urandom(32'd20240611));

    #2 rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) readLit("R1 reset readback", 4'(a), 32'h0);
    checkEq("R1 irq after reset", {31'd0, irq}, 32'h0);

    // R2 select layout and unmapped holes
    cyc(1'b1, 4'h0, 32'h76543210);
    cyc(1'b1, 4'h3, 32'hFEDCBA98);
    readLit("R2 select word 0", 4'h0, 32'h76543210);
    readLit("R2 select word 3", 4'h3, 32'hFEDCBA98);
    readLit("R2 select word 1", 4'h1, 32'h0);
    cyc(1'b1, 4'h5, 32'hFFFFFFFF);
    cyc(1'b1, 4'hD, 32'hFFFFFFFF);
    readLit("R2 hole reads zero", 4'h5, 32'h0);
    readLit("R2 hole write no effect sel", 4'h1, 32'h0);
    readLit("R2 hole write no effect en", 4'h8, 32'h0);
    cyc(1'b1, 4'h0, 32'h0);
    cyc(1'b1, 4'h3, 32'h0);

    // R3 every select code on queue 5
    cyc(1'b1, 4'h8, 32'h1 << 5);
    for (int c = 0; c < 16; c++) begin
      logic [3:0] code;
      code = 4'(c);
      cyc(1'b1, 4'h0, {8'h0, code, 20'h0});
      setFlag(int'(code[1:0]), 5, code[2]);
      idle();
      cyc(1'b1, 4'hA, 32'hFFFFFFFF);
      readLit("R3 quiet before rise", 4'hA, 32'h0);
      setFlag(int'(code[1:0]), 5, ~code[2]);
      idle();
      readLit("R3 selected condition sets bit", 4'hA, 32'h1 << 5);
    end

    // R4 one-edge latency on queue 9 watching full
    fF[9] = 1'b0;
    cyc(1'b1, 4'h1, 32'h0000_0030);
    cyc(1'b1, 4'h8, 32'h0000_0220);
    cyc(1'b1, 4'hA, 32'hFFFFFFFF);
    readLit("R4 clear before event", 4'hA, 32'h0);
    fF[9] = 1'b1;
    idle();
    readLit("R4 bit after one edge", 4'hA, 32'h200);
    checkEq("R4 irq after one edge", {31'd0, irq}, 32'h1);

    // R6 sticky
    fF[9] = 1'b0;
    idle();
    readLit("R6 still pending after fall", 4'hA, 32'h200);

    // R7 write-one-to-clear
    cyc(1'b1, 4'hA, ~32'h200);
    readLit("R7 zero leaves bit", 4'hA, 32'h200);
    cyc(1'b1, 4'hA, 32'h200);
    readLit("R7 one clears bit", 4'hA, 32'h0);

    // R8 event beats a simultaneous clear
    fF[9] = 1'b1; idle();
    fF[9] = 1'b0; idle();
    fF[9] = 1'b1;
    cyc(1'b1, 4'hA, 32'h200);
    readLit("R8 event wins over clear", 4'hA, 32'h200);

    // R5 disabled queue ignores events
    cyc(1'b1, 4'h8, 32'h20);
    cyc(1'b1, 4'hA, 32'hFFFFFFFF);
    fF[9] = 1'b0; idle();
    fF[9] = 1'b1; idle();
    readLit("R5 no set while disabled", 4'hA, 32'h0);
    cyc(1'b1, 4'h8, 32'h220);
    idle(); idle();
    readLit("R5 enable on high level sets nothing", 4'hA, 32'h0);
    checkEq("R5 irq stays low", {31'd0, irq}, 32'h0);

    // R9 upper group
    cyc(1'b1, 4'h9, 32'h8000_0000);
    fU[31] = 1'b1; fU[3] = 1'b1;
    idle();
    readLit("R9 upper nearly empty sets bit", 4'hB, 32'h8000_0000);
    checkEq("R9 irq from upper", {31'd0, irq}, 32'h1);

    // R10 enable masks the line, not the bit
    cyc(1'b1, 4'h9, 32'h0);
    checkEq("R10 irq drops on disable", {31'd0, irq}, 32'h0);
    readLit("R10 pending kept", 4'hB, 32'h8000_0000);
    cyc(1'b1, 4'h9, 32'h8000_0000);
    checkEq("R10 irq returns on enable", {31'd0, irq}, 32'h1);
    cyc(1'b1, 4'hB, 32'hFFFFFFFF);
    checkEq("R10 irq low after clear", {31'd0, irq}, 32'h0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      for (int q = 0; q < 32; q++) begin
        if ($urandom % 8 == 0) fE[q]  = ~fE[q];
        if ($urandom % 8 == 0) fNE[q] = ~fNE[q];
        if ($urandom % 8 == 0) fNF[q] = ~fNF[q];
        if ($urandom % 8 == 0) fF[q]  = ~fF[q];
        if ($urandom % 8 == 0) fU[q]  = ~fU[q];
      end
      if ($urandom % 4 == 0) cyc(1'b1, 4'($urandom % 16), $urandom);
      else idle();
      if (n % 32 == 31) begin
        for (int a = 0; a < 4; a++) readChk("R2 random select readback", 4'(a));
        readChk("R2 random hole", 4'h6);
        readChk("R4 random lower enable", 4'h8);
        readChk("R9 random upper enable", 4'h9);
        readChk("R4 random lower pending", 4'hA);
        readChk("R9 random upper pending", 4'hB);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule